// File: doc/BRIEF.md
# Dithered Fractional-Period Pulse Generator

The block produces a train of single-clock pulses whose long-run spacing equals a programmed period. The period is an unsigned fixed-point count of clock cycles and may have a fractional part. A divider that only counts whole cycles cannot hit a fractional period exactly. This block therefore picks a whole delay for every interval. To pick it, the block takes the programmed period and subtracts a stored error term. It then adds triangular-distribution noise, built from two independent pseudo-random uniforms, and takes the floor. A down-counter runs out that delay, and the pulse marks the end of each interval.

With error feedback selected, the block keeps the difference between the chosen delay and the corrected target. That difference is subtracted from the next target. The summed timing error then stays bounded instead of wandering, at the price of more cycle-to-cycle jitter. With feedback off, every interval is an independent dithered rounding of the period.

The period word and the two enables are plain control pins with no handshake. The pulse and the current interval's count are plain outputs. The period word is sampled only at interval boundaries.

Top module: `dpg_pulse_gen`

## Requirements
- R1: While reset is high, and on the first clock after reset ends, `pulse_o` is 0 and `count_o` is 0.
- R2: The number of clock cycles from one pulse to the next equals the value `count_o` shows in the cycle of the later pulse. Each pulse lasts one clock. The first pulse after enable comes that many cycles after the first cycle in which `en` is sampled high.
- R3: With feedback on and a constant period P ≥ 2.0, the sum of the chosen delays after n intervals stays within ±2 cycles of n·P. The count n starts when enable rises. P is `period_i` / 65536 (16 fractional bits).
- R4: With feedback off, every chosen delay d satisfies floor(P − 0.5) ≤ d ≤ floor(P + 1.5 − 2^-15), and d is never below 1.
- R5: A period word below 2.0 (0x20000) acts exactly as 2.0, for both the R3 bound and the R4 range.
- R6: While `en` is low, `pulse_o` is 0 and `count_o` is 0. The counter and the error term are cleared, so re-enabling starts a fresh sequence.
- R7: A change of `period_i` in the middle of an interval does not change that interval's length. It applies from the next delay chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low clears the sequence |
| fb_en | input | 1 | Selects first-order error feedback |
| period_i | input | 48 | Period in cycles, unsigned, 32 integer and 16 fractional bits |
| pulse_o | output | 1 | One-clock pulse at each interval end |
| count_o | output | 33 | Whole-cycle length of the current interval |

## Verification
The assertions rely on two things. First, the stored error term stays within ±2 cycles. Second, a loaded delay is at least one. Both hold only if the period word does not come within a few cycles of the 32-bit integer ceiling. The stimulus keeps to periods from below 2.0 up to about 8334 cycles, far inside that range.

The period word is changed only while `en` is low, or once in the middle of an interval for the R7 case. The R3 drift bound is therefore always measured from a cleared error term under a constant period.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  localparam int DEF_INT_W  = 32;
  localparam int DEF_FRAC_W = 16;
  localparam int DEF_LFSR_W = 32;

  // Feedback tap mask for a maximal-length Fibonacci shift register of width w
  function automatic logic [63:0] lfsr_taps(input int w);
    case (w)
      16:      return 64'h0000_0000_0000_D008;
      24:      return 64'h0000_0000_00E1_0000;
      64:      return 64'hD800_0000_0000_0000;
      default: return 64'h0000_0000_8020_0003;
    endcase
  endfunction

  // Distinct nonzero start states per generator index
  function automatic logic [63:0] lfsr_seed(input int idx);
    return (idx == 0) ? 64'h5A5A_C3E1_ACE1_2468 : 64'h0F1E_2D3C_1357_9BDF;
  endfunction
endpackage

// File: rtl/dpg_lfsr.sv
module dpg_lfsr #(
  parameter int W = 32,
  parameter int OUT_W = 16,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'hACE1_2468
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] st;
  logic         fb;

  assign fb    = ^(st & TAPS);
  assign rnd_o = st[W-1 -: OUT_W];

  always_ff @(posedge clk) begin
    if (rst) st <= SEED;
    else     st <= {st[W-2:0], fb};
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
    st != '0);  // R3
endmodule

// File: rtl/dpg_quant.sv
module dpg_quant #(
  parameter int INT_W  = 32,
  parameter int FRAC_W = 16
) (
  input  logic [INT_W+FRAC_W-1:0]        period_i,
  input  logic signed [INT_W+FRAC_W+2:0] err_i,
  input  logic [FRAC_W-1:0]              r1_i,
  input  logic [FRAC_W-1:0]              r2_i,
  output logic [INT_W:0]                 delay_o,
  output logic signed [INT_W+FRAC_W+2:0] err_o
);
  localparam int PW = INT_W + FRAC_W;
  localparam int SW = PW + 3;
  localparam int CW = INT_W + 1;
  localparam logic [PW-1:0]        MIN_P = PW'(2) << FRAC_W;
  localparam logic signed [SW-1:0] HALF  = SW'(1) << (FRAC_W - 1);
  localparam logic signed [SW-1:0] ONE   = SW'(1);

  logic [PW-1:0]        pc;
  logic signed [SW-1:0] target, dith, sum, q, dl_s;

  always_comb begin
    pc     = (period_i < MIN_P) ? MIN_P : period_i;
    target = $signed({3'b000, pc}) - err_i;
    dith   = $signed({{(SW-FRAC_W){1'b0}}, r1_i}) + $signed({{(SW-FRAC_W){1'b0}}, r2_i}) - HALF;
    sum    = target + dith;
    q      = sum >>> FRAC_W;
    if (q < ONE) delay_o = CW'(1);
    else         delay_o = q[CW-1:0];
    dl_s   = $signed({2'b00, delay_o, {FRAC_W{1'b0}}});
    err_o  = dl_s - target;
  end
endmodule

// File: rtl/dpg_timer.sv
module dpg_timer #(
  parameter int CW = 33
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] delay_i,
  output logic          load_o,
  output logic          pulse_o,
  output logic [CW-1:0] count_o
);
  logic          active;
  logic [CW-1:0] cnt;

  assign load_o  = en && (!active || cnt == '0);
  assign pulse_o = en && active && cnt == '0;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active  <= 1'b0;
      cnt     <= '0;
      count_o <= '0;
    end else if (load_o) begin
      active  <= 1'b1;
      cnt     <= delay_i - CW'(1);
      count_o <= delay_i;
    end else begin
      cnt     <= cnt - CW'(1);
    end
  end

  AST_LOAD_MIN: assert property (@(posedge clk) disable iff (rst)
    load_o |-> delay_i != '0);  // R2
  AST_CNT_BELOW: assert property (@(posedge clk) disable iff (rst)
    active |-> cnt < count_o);  // R2
endmodule

// File: rtl/dpg_pulse_gen.sv
module dpg_pulse_gen #(
  parameter int INT_W  = dpg_pkg::DEF_INT_W,
  parameter int FRAC_W = dpg_pkg::DEF_FRAC_W,
  parameter int LFSR_W = dpg_pkg::DEF_LFSR_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    fb_en,
  input  logic [INT_W+FRAC_W-1:0] period_i,
  output logic                    pulse_o,
  output logic [INT_W:0]          count_o
);
  localparam int PW = INT_W + FRAC_W;
  localparam int SW = PW + 3;
  localparam int CW = INT_W + 1;
  localparam int NGEN = 2;
  localparam logic signed [SW-1:0] ERR_LIM = SW'(2) << FRAC_W;

  logic [FRAC_W-1:0]    rnd [NGEN];
  logic signed [SW-1:0] err_q, err_nx;
  logic [CW-1:0]        delay;
  logic                 load;

  for (genvar g = 0; g < NGEN; g++) begin : g_rng
    dpg_lfsr #(
      .W(LFSR_W), .OUT_W(FRAC_W),
      .TAPS(LFSR_W'(dpg_pkg::lfsr_taps(LFSR_W))),
      .SEED(LFSR_W'(dpg_pkg::lfsr_seed(g)))
    ) u_lfsr (.clk(clk), .rst(rst), .rnd_o(rnd[g]));
  end

  dpg_quant #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_quant (
    .period_i(period_i), .err_i(err_q), .r1_i(rnd[0]), .r2_i(rnd[1]),
    .delay_o(delay), .err_o(err_nx));

  dpg_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .en(en), .delay_i(delay),
    .load_o(load), .pulse_o(pulse_o), .count_o(count_o));

  always_ff @(posedge clk) begin
    if (rst || !en || !fb_en) err_q <= '0;
    else if (load)            err_q <= err_nx;
  end

  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (rst)
    (err_q <= ERR_LIM) && (err_q >= -ERR_LIM));  // R3
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !fb_en |=> err_q == '0);  // R4
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pulse_o && count_o == '0));  // R6
endmodule

// File: tb/dpg_pulse_gen_tb.sv
module dpg_pulse_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 195000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        fb_en = 1'b0;
  logic [47:0] period = '0;
  logic        pulse_o;
  logic [32:0] count_o;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpg_pulse_gen u_dut (.clk(clk), .rst(rst), .en(en), .fb_en(fb_en),
    .period_i(period), .pulse_o(pulse_o), .count_o(count_o));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint eff_period(input logic [47:0] pw);
    return (pw < 48'h20000) ? 64'h20000 : longint'(pw);
  endfunction
  function automatic longint d_lo(input logic [47:0] pw);
    longint l = (eff_period(pw) - 32768) >>> 16;
    return (l < 1) ? 1 : l;
  endfunction
  function automatic longint d_hi(input logic [47:0] pw);
    return (eff_period(pw) + 131070 - 32768) >>> 16;
  endfunction

  // wait for next pulse; returns cycles counted from the current negedge
  task automatic wait_pulse(input longint lim, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!pulse_o && k < lim);
  endtask

  task automatic run(input logic [47:0] pw, input bit fb, input int n);
    longint pc, sum, diff, d;
    int k;
    string tag;
    pc  = eff_period(pw);
    tag = (pw < 48'h20000) ? "R5" : (fb ? "R3" : "R4");
    @(negedge clk);
    en = 1'b0; period = pw; fb_en = fb;
    @(negedge clk);
    check(!pulse_o && count_o == 0, "R6 idle while disabled", longint'(count_o) + pulse_o, 0);
    en = 1'b1;
    sum = 0;
    for (int i = 1; i <= n; i++) begin
      wait_pulse(d_hi(pw) + 3, k);
      d = longint'(count_o);
      check(pulse_o && k == d, "R2 spacing", k, d);
      sum += d;
      if (fb) begin
        diff = sum * 65536 - longint'(i) * pc;
        check(diff <= 131072 && diff >= -131072, {tag, " drift"}, diff, 0);
      end else begin
        check(d >= d_lo(pw) && d <= d_hi(pw), {tag, " range"}, d, d_lo(pw));
      end
    end
  endtask

  initial begin
    int k;
    longint c;
    logic [47:0] newpw;
    void'($urandom(32'd1234));
    en = 1'b1;
    period = 48'h50000;
    repeat (3) @(negedge clk);
    check(!pulse_o && count_o == 0, "R1 in reset", longint'(count_o) + pulse_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!pulse_o, "R1 after reset pulse", pulse_o, 0);

    run(48'h54000, 1'b1, 400);          // 5.25
    run(48'h70000, 1'b0, 200);          // 7.0 exact
    run(48'h08000, 1'b1, 300);          // 0.5 clamped
    run(48'h00000, 1'b0, 200);          // 0 clamped
    run(48'h1FFFF, 1'b1, 200);          // just below 2.0
    run(48'h20000, 1'b1, 200);          // exactly 2.0
    run(48'h2_8000, 1'b0, 200);         // 2.5

    for (int t = 0; t < 6; t++) begin
      logic [47:0] pw = 48'($urandom_range(32'h20000, 32'h280000));
      run(pw, 1'($urandom_range(0, 1)), 150);
    end

    // disable in mid-run: quiet outputs
    @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!pulse_o && count_o == 0, "R6 disabled", longint'(count_o) + pulse_o, 0);
    end

    // R7: change period mid-interval
    run(48'hC_4000, 1'b0, 3);           // 12.25
    @(negedge clk);
    c = longint'(count_o);
    newpw = 48'h3_0000;
    period = newpw;
    wait_pulse(40, k);
    check(pulse_o && longint'(k + 1) == c, "R7 current interval kept", k + 1, c);
    wait_pulse(40, k);
    check(longint'(count_o) >= d_lo(newpw) && longint'(count_o) <= d_hi(newpw),
          "R7 new period applied", count_o, d_lo(newpw));
    check(k == int'(count_o), "R2 spacing after change", k, count_o);

    // long period with feedback
    run(48'h208D_5555, 1'b1, 8);        // about 8333.33

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule